// File: doc/BRIEF.md
# Two-Register Accumulator Processor

This block is a compact processor core with an accumulator `A`, a second data register `B`, a carry flag and a zero flag. Code and data share one internal byte-wide memory. Each instruction is two bytes: an opcode byte followed by an operand byte. Every instruction completes in a single clock. The operand carries a direct address, an immediate value or a branch target. No instruction takes an address from a register or from memory. Nothing saves the program counter, so the core has no call, return or stack. Because code and data share one memory, a program may rewrite its own instruction bytes.

A host fills the memory through a write port while it holds the core in reset. After the host releases reset, the core runs from address zero until it executes a halt instruction. It then raises `halted` and freezes its state. The registers, program counter and flags are brought out on debug outputs for inspection.

Top module: `tiny_acc_cpu`

## Requirements
- R1: While `rst` is high, each rising clock edge clears PC, A, B, carry, zero and `halted` to 0, and stores `hostData` at `hostAddr` when `hostWe` is high.
- R2: While `rst` is low, `hostWe` has no effect on memory.
- R3: One instruction executes per clock. The opcode is read at PC and the operand at PC+1, and PC then advances by 2, modulo 256. Opcodes: 0x00 NOP, 0x01 LDA, 0x02 STA, 0x03 LDI, 0x04 A-to-B move, 0x05 B-to-A move, 0x06 ADD, 0x07 SUB, 0x08 NAND, 0x09 NOR, 0x0A branch-on-carry, 0x0B branch-on-zero, 0x0C JMP, 0x0F HALT.
- R4: LDA loads A from memory at the operand address. LDI loads the operand into A. STA writes A to memory at the operand address. None of them changes the flags.
- R5: The A-to-B and B-to-A moves copy one register into the other and leave both flags unchanged.
- R6: ADD sets A to (A+B) mod 256 and carry to the carry out. Zero is set when the result is 0.
- R7: SUB sets A to (A−B) mod 256 and carry to 1 exactly when A < B unsigned. Zero is set when the result is 0.
- R8: NAND sets A to ~(A&B) and NOR sets A to ~(A|B). Both set zero from the result and clear carry.
- R9: Branch-on-carry and branch-on-zero load PC from the operand when their flag is 1, and otherwise advance PC by 2. JMP always loads PC from the operand.
- R10: HALT raises `halted` on the edge that executes it. PC stays at the HALT address. PC, A, B and the flags then stay constant until reset.
- R11: NOP and any undefined opcode change nothing except advancing PC by 2.
- R12: Code and data share one 256-byte memory, so a store into an instruction byte changes what is fetched later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables host writes |
| hostWe | input | 1 | Host memory write strobe, honoured only in reset |
| hostAddr | input | 8 | Host write address |
| hostData | input | 8 | Host write data |
| halted | output | 1 | High once HALT has executed |
| dbgA | output | 8 | Accumulator A |
| dbgB | output | 8 | Register B |
| dbgPc | output | 8 | Program counter |
| dbgCarry | output | 1 | Carry flag |
| dbgZero | output | 1 | Zero flag |

## Verification
The four ALU operations are swept over a 16 by 16 grid of operand values. The grid includes 0 to 3, 252 to 255 and a scattered middle, so carry-out, borrow, zero results and all-ones NAND/NOR results are separated from the ordinary cases. A comparison sweep over all pairs from 0 to 7 feeds SUB into a chain of carry and zero branches. That sweep tells below, equal and above apart by the landing address. Directed programs check the other behaviour:
- Flags left set across loads and moves show that those instructions do not touch the flags.
- A store into an operand byte shows that the memory is shared between code and data.
- A host write during execution shows that the write port is ignored outside reset.
- Cycle counts and a wait after HALT show single-cycle issue and the halt freeze.

// File: rtl/tacc_pkg.sv
package tacc_pkg;
  parameter int unsigned WORD_W = 8;
  localparam int unsigned MEM_DEPTH = 1 << WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t OP_NOP  = word_t'(8'h00);
  localparam word_t OP_LDA  = word_t'(8'h01);
  localparam word_t OP_STA  = word_t'(8'h02);
  localparam word_t OP_LDI  = word_t'(8'h03);
  localparam word_t OP_MAB  = word_t'(8'h04);
  localparam word_t OP_MBA  = word_t'(8'h05);
  localparam word_t OP_ADD  = word_t'(8'h06);
  localparam word_t OP_SUB  = word_t'(8'h07);
  localparam word_t OP_NAND = word_t'(8'h08);
  localparam word_t OP_NOR  = word_t'(8'h09);
  localparam word_t OP_BRC  = word_t'(8'h0A);
  localparam word_t OP_BRZ  = word_t'(8'h0B);
  localparam word_t OP_JMP  = word_t'(8'h0C);
  localparam word_t OP_HALT = word_t'(8'h0F);

  typedef enum logic [1:0] {ASRC_MEM, ASRC_IMM, ASRC_B, ASRC_ALU} aSrc_e;
  typedef enum logic [1:0] {PC_STEP, PC_JUMP, PC_HOLD} pcSel_e;
  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_NAND, ALU_NOR} aluOp_e;

  typedef struct packed {
    logic   loadA;
    aSrc_e  aSrc;
    logic   loadB;
    logic   loadFlags;
    logic   memWe;
    pcSel_e pcSel;
    aluOp_e aluOp;
  } ctrl_t;
endpackage

// File: rtl/tacc_control.sv
module tacc_control
  import tacc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  word_t opByte,
  input  logic  carryF,
  input  logic  zeroF,
  output ctrl_t ctrl,
  output logic  halted
);
  logic haltedQ;

  always_comb begin
    ctrl = '{loadA: 1'b0, aSrc: ASRC_ALU, loadB: 1'b0, loadFlags: 1'b0,
             memWe: 1'b0, pcSel: PC_STEP, aluOp: ALU_ADD};
    if (haltedQ) begin
      ctrl.pcSel = PC_HOLD;
    end else begin
      case (opByte)
        OP_LDA:  begin ctrl.loadA = 1'b1; ctrl.aSrc = ASRC_MEM; end
        OP_STA:  ctrl.memWe = 1'b1;
        OP_LDI:  begin ctrl.loadA = 1'b1; ctrl.aSrc = ASRC_IMM; end
        OP_MAB:  ctrl.loadB = 1'b1;
        OP_MBA:  begin ctrl.loadA = 1'b1; ctrl.aSrc = ASRC_B; end
        OP_ADD:  begin ctrl.loadA = 1'b1; ctrl.loadFlags = 1'b1; ctrl.aluOp = ALU_ADD; end
        OP_SUB:  begin ctrl.loadA = 1'b1; ctrl.loadFlags = 1'b1; ctrl.aluOp = ALU_SUB; end
        OP_NAND: begin ctrl.loadA = 1'b1; ctrl.loadFlags = 1'b1; ctrl.aluOp = ALU_NAND; end
        OP_NOR:  begin ctrl.loadA = 1'b1; ctrl.loadFlags = 1'b1; ctrl.aluOp = ALU_NOR; end
        OP_BRC:  ctrl.pcSel = carryF ? PC_JUMP : PC_STEP;
        OP_BRZ:  ctrl.pcSel = zeroF ? PC_JUMP : PC_STEP;
        OP_JMP:  ctrl.pcSel = PC_JUMP;
        OP_HALT: ctrl.pcSel = PC_HOLD;
        default: ;  // NOP and undefined opcodes only step the PC
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      haltedQ <= 1'b0;
    else if (opByte == OP_HALT)
      haltedQ <= 1'b1;
  end

  assign halted = haltedQ;
endmodule

// File: rtl/tacc_datapath.sv
module tacc_datapath
  import tacc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl,
  input  logic  hostWe,
  input  word_t hostAddr,
  input  word_t hostData,
  output word_t opByte,
  output word_t argByte,
  output word_t accA,
  output word_t regB,
  output word_t pc,
  output logic  carryF,
  output logic  zeroF
);
  word_t mem [MEM_DEPTH];
  word_t pcArg;
  word_t memData;
  word_t aluRes;
  logic  aluCarry;
  word_t aNext;
  word_t pcNext;

  assign pcArg   = pc + word_t'(1);
  assign opByte  = mem[pc];
  assign argByte = mem[pcArg];
  assign memData = mem[argByte];

  always_comb begin
    aluCarry = 1'b0;
    aluRes   = '0;
    case (ctrl.aluOp)
      ALU_ADD:  {aluCarry, aluRes} = {1'b0, accA} + {1'b0, regB};
      ALU_SUB:  {aluCarry, aluRes} = {1'b0, accA} - {1'b0, regB};
      ALU_NAND: aluRes = ~(accA & regB);
      ALU_NOR:  aluRes = ~(accA | regB);
      default:  ;
    endcase
  end

  always_comb begin
    case (ctrl.aSrc)
      ASRC_MEM: aNext = memData;
      ASRC_IMM: aNext = argByte;
      ASRC_B:   aNext = regB;
      default:  aNext = aluRes;
    endcase
  end

  always_comb begin
    case (ctrl.pcSel)
      PC_JUMP: pcNext = argByte;
      PC_HOLD: pcNext = pc;
      default: pcNext = pc + word_t'(2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      accA   <= '0;
      regB   <= '0;
      carryF <= 1'b0;
      zeroF  <= 1'b0;
    end else begin
      pc <= pcNext;
      if (ctrl.loadA) accA <= aNext;
      if (ctrl.loadB) regB <= accA;
      if (ctrl.loadFlags) begin
        carryF <= aluCarry;
        zeroF  <= (aluRes == '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (hostWe) mem[hostAddr] <= hostData;
    end else if (ctrl.memWe) begin
      mem[argByte] <= accA;
    end
  end
endmodule

// File: rtl/tiny_acc_cpu.sv
module tiny_acc_cpu
  import tacc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  hostWe,
  input  word_t hostAddr,
  input  word_t hostData,
  output logic  halted,
  output word_t dbgA,
  output word_t dbgB,
  output word_t dbgPc,
  output logic  dbgCarry,
  output logic  dbgZero
);
  ctrl_t ctrl;
  word_t opByte;
  word_t argByte;

  tacc_control u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opByte (opByte),
    .carryF (dbgCarry),
    .zeroF  (dbgZero),
    .ctrl   (ctrl),
    .halted (halted)
  );

  tacc_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .hostWe   (hostWe),
    .hostAddr (hostAddr),
    .hostData (hostData),
    .opByte   (opByte),
    .argByte  (argByte),
    .accA     (dbgA),
    .regB     (dbgB),
    .pc       (dbgPc),
    .carryF   (dbgCarry),
    .zeroF    (dbgZero)
  );
endmodule

// File: rtl/tacc_checker.sv
module tacc_checker
  import tacc_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  halted,
  input word_t pc,
  input word_t a,
  input word_t b,
  input logic  carry,
  input logic  zero,
  input word_t opByte,
  input word_t argByte
);
  logic rstQ = 1'b0;
  always_ff @(posedge clk) rstQ <= rst;

  // R1: one edge in reset leaves everything cleared
  always @(negedge clk) begin
    if (rstQ)
      assert_reset_clear_R1: assert (pc == '0 && a == '0 && b == '0 && !carry && !zero && !halted)
        else $error("reset state not clear");
  end

  assert_add_result_R6: assert property (@(posedge clk) disable iff (rst)
    (!halted && opByte == OP_ADD) |=> {carry, a} == ({1'b0, $past(a)} + {1'b0, $past(b)}));

  assert_sub_borrow_R7: assert property (@(posedge clk) disable iff (rst)
    (!halted && opByte == OP_SUB) |=> carry == ($past(a) < $past(b)));

  assert_logic_no_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (!halted && (opByte == OP_NAND || opByte == OP_NOR)) |=> !carry);

  // R4 and R5: loads and moves keep the flags
  assert_move_keeps_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (!halted && (opByte == OP_MAB || opByte == OP_MBA || opByte == OP_LDA || opByte == OP_LDI))
    |=> ($stable(carry) && $stable(zero)));

  assert_jump_target_R9: assert property (@(posedge clk) disable iff (rst)
    (!halted && opByte == OP_JMP) |=> pc == $past(argByte));

  assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(a) && $stable(b) && $stable(carry) && $stable(zero)));
endmodule

bind tiny_acc_cpu tacc_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .halted  (halted),
  .pc      (dbgPc),
  .a       (dbgA),
  .b       (dbgB),
  .carry   (dbgCarry),
  .zero    (dbgZero),
  .opByte  (opByte),
  .argByte (argByte)
);

// File: tb/sim_tiny_acc_cpu.sv
`timescale 1ns/1ps
module sim_tiny_acc_cpu;
  localparam logic [7:0] I_NOP = 8'h00, I_LDA = 8'h01, I_STA = 8'h02, I_LDI = 8'h03,
                         I_MAB = 8'h04, I_MBA = 8'h05, I_ADD = 8'h06, I_SUB = 8'h07,
                         I_NAND = 8'h08, I_NOR = 8'h09, I_BRC = 8'h0A, I_BRZ = 8'h0B,
                         I_JMP = 8'h0C, I_HLT = 8'h0F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hostWe = 1'b0;
  logic [7:0] hostAddr = '0, hostData = '0;
  logic halted, dbgCarry, dbgZero;
  logic [7:0] dbgA, dbgB, dbgPc;

  int nChecks = 0;
  int nFails = 0;
  int cycCount = 0;
  logic [7:0] stAddr [0:63];
  logic [7:0] stVal  [0:63];
  int stN = 0;
  int cursor = 0;

  always #2 clk = ~clk;

  tiny_acc_cpu u0 (
    .clk(clk), .rst(rst), .hostWe(hostWe), .hostAddr(hostAddr), .hostData(hostData),
    .halted(halted), .dbgA(dbgA), .dbgB(dbgB), .dbgPc(dbgPc),
    .dbgCarry(dbgCarry), .dbgZero(dbgZero)
  );

  always @(posedge clk) begin
    cycCount++;
    if (cycCount == 190000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R10 actual=running expected=halted");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic newProg();
    stN = 0;
    cursor = 0;
  endtask

  task automatic poke(input logic [7:0] addr, input logic [7:0] val);
    stAddr[stN] = addr;
    stVal[stN] = val;
    stN++;
  endtask

  task automatic emit(input logic [7:0] op, input logic [7:0] arg);
    poke(8'(cursor), op);
    poke(8'(cursor + 1), arg);
    cursor += 2;
  endtask

  task automatic runProg(input int limit, input bit hostPoke, output int cycles);
    rst = 1'b1;
    for (int i = 0; i < stN; i++) begin
      hostWe = 1'b1;
      hostAddr = stAddr[i];
      hostData = stVal[i];
      @(negedge clk);
    end
    hostWe = 1'b0;
    rst = 1'b0;
    if (hostPoke) begin
      hostWe = 1'b1;
      hostAddr = 8'h90;
      hostData = 8'h99;
    end
    cycles = 0;
    while (!halted && cycles < limit) begin
      @(negedge clk);
      cycles++;
      if (cycles == 2) hostWe = 1'b0;
    end
    hostWe = 1'b0;
    check("R10 halted reached", int'(halted), 1);
  endtask

  function automatic logic [7:0] sweepVal(input int i);
    if (i < 4) return 8'(i);
    if (i < 8) return 8'(255 - (i - 4));
    return 8'(i * 53 + 11);
  endfunction

  initial begin
    int cyc;
    logic [7:0] opList [0:3];
    opList[0] = I_ADD; opList[1] = I_SUB; opList[2] = I_NAND; opList[3] = I_NOR;

    // R1: reset state
    @(negedge clk);
    @(negedge clk);
    check("R1 pc", int'(dbgPc), 0);
    check("R1 A", int'(dbgA), 0);
    check("R1 B", int'(dbgB), 0);
    check("R1 flags", int'({dbgCarry, dbgZero}), 0);
    check("R1 halted", int'(halted), 0);

    // R6 R7 R8: ALU sweep
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        for (int k = 0; k < 4; k++) begin
          logic [7:0] va, vb, er;
          int ec;
          string tag;
          va = sweepVal(i);
          vb = sweepVal(j);
          newProg();
          emit(I_LDI, vb); emit(I_MAB, 8'h00); emit(I_LDI, va);
          emit(opList[k], 8'h00); emit(I_HLT, 8'h00);
          runProg(20, 1'b0, cyc);
          case (k)
            0: begin er = 8'(int'(va) + int'(vb)); ec = (int'(va) + int'(vb) > 255) ? 1 : 0; tag = "R6 add"; end
            1: begin er = 8'(int'(va) - int'(vb)); ec = (va < vb) ? 1 : 0; tag = "R7 sub"; end
            2: begin er = ~(va & vb); ec = 0; tag = "R8 nand"; end
            default: begin er = ~(va | vb); ec = 0; tag = "R8 nor"; end
          endcase
          check($sformatf("%s A a=%0h b=%0h", tag, va, vb), int'(dbgA), int'(er));
          check($sformatf("%s carry a=%0h b=%0h", tag, va, vb), int'(dbgCarry), ec);
          check($sformatf("%s zero a=%0h b=%0h", tag, va, vb), int'(dbgZero), (er == 8'h00) ? 1 : 0);
          check($sformatf("R5 move B=%0h", vb), int'(dbgB), int'(vb));
        end
      end
    end

    // R9: compare and branch sweep
    for (int x = 0; x < 8; x++) begin
      for (int y = 0; y < 8; y++) begin
        int expA, expPc;
        newProg();
        emit(I_LDI, 8'(x)); emit(I_MAB, 8'h00); emit(I_LDI, 8'(y)); emit(I_SUB, 8'h00);
        emit(I_BRC, 8'd16); emit(I_BRZ, 8'd20); emit(I_LDI, 8'd1); emit(I_HLT, 8'h00);
        emit(I_LDI, 8'd2); emit(I_HLT, 8'h00); emit(I_LDI, 8'd3); emit(I_HLT, 8'h00);
        runProg(30, 1'b0, cyc);
        if (y < x) begin expA = 2; expPc = 18; end
        else if (y == x) begin expA = 3; expPc = 22; end
        else begin expA = 1; expPc = 14; end
        check($sformatf("R9 branch y=%0d x=%0d A", y, x), int'(dbgA), expA);
        check($sformatf("R10 halt pc y=%0d x=%0d", y, x), int'(dbgPc), expPc);
      end
    end

    // R4 R5: flags survive loads, moves and stores
    newProg();
    emit(I_LDI, 8'hFF); emit(I_MAB, 8'h00); emit(I_LDI, 8'h01); emit(I_ADD, 8'h00);
    emit(I_LDI, 8'h05); emit(I_MAB, 8'h00); emit(I_LDA, 8'h40); emit(I_MBA, 8'h00);
    emit(I_STA, 8'h41); emit(I_HLT, 8'h00);
    poke(8'h40, 8'h9C);
    runProg(30, 1'b0, cyc);
    check("R5 A after move", int'(dbgA), 5);
    check("R5 B after move", int'(dbgB), 5);
    check("R4 R5 flags kept", int'({dbgCarry, dbgZero}), 3);

    // R1: reset after a busy run
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset A", int'(dbgA), 0);
    check("R1 reset flags", int'({dbgCarry, dbgZero}), 0);
    check("R1 reset halted", int'(halted), 0);

    // R4: store then load back; LDI 0 leaves zero flag clear
    newProg();
    emit(I_LDI, 8'h5A); emit(I_STA, 8'h80); emit(I_LDI, 8'h00);
    emit(I_LDA, 8'h80); emit(I_HLT, 8'h00);
    runProg(20, 1'b0, cyc);
    check("R4 store/load A", int'(dbgA), 8'h5A);
    check("R4 load no zero flag", int'(dbgZero), 0);

    // R12: program rewrites its own operand
    newProg();
    emit(I_LDI, 8'h44); emit(I_STA, 8'h05); emit(I_LDI, 8'h00); emit(I_HLT, 8'h00);
    runProg(20, 1'b0, cyc);
    check("R12 self-modified operand", int'(dbgA), 8'h44);

    // R9: unconditional jump skips an instruction
    newProg();
    emit(I_LDI, 8'h07); emit(I_JMP, 8'h06); emit(I_LDI, 8'h09); emit(I_HLT, 8'h00);
    runProg(20, 1'b0, cyc);
    check("R9 jmp A", int'(dbgA), 7);
    check("R9 jmp pc", int'(dbgPc), 6);

    // R2: host write while running is ignored
    newProg();
    emit(I_NOP, 8'h00); emit(I_LDA, 8'h90); emit(I_HLT, 8'h00);
    poke(8'h90, 8'h33);
    runProg(20, 1'b1, cyc);
    check("R2 host write ignored", int'(dbgA), 8'h33);

    // R11 R3: NOP and undefined opcode, one instruction per clock
    newProg();
    emit(I_LDI, 8'h04); emit(I_NOP, 8'h99); emit(8'hE7, 8'h33); emit(I_HLT, 8'h00);
    runProg(20, 1'b0, cyc);
    check("R3 cycles to halt", cyc, 4);
    check("R11 A", int'(dbgA), 4);
    check("R11 B", int'(dbgB), 0);
    check("R11 flags", int'({dbgCarry, dbgZero}), 0);
    check("R10 pc at halt", int'(dbgPc), 6);

    // R10: frozen after halt
    for (int n = 0; n < 8; n++) @(negedge clk);
    check("R10 pc frozen", int'(dbgPc), 6);
    check("R10 A frozen", int'(dbgA), 4);
    check("R10 still halted", int'(halted), 1);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule